// File: doc/BRIEF.md
# PIO Drive Timing Count Generator

This block converts a requested disk PIO transfer mode and the frequency of the bus clock, given in whole MHz, into four 8-bit clock counts that program one drive's strobe timing. It also produces the four internal register indexes that receive those counts. The indexes depend on which drive is being set up. A one-cycle start pulse captures the inputs. A fixed number of cycles later, a one-cycle done pulse marks all eight outputs as valid. The outputs then keep their values until the next calculation completes.

Each mode has a nominal full cycle time and an active strobe time in nanoseconds. Both are turned into clock counts with a division that rounds up. The division runs bit by bit in two sequential dividers that work in parallel. One pair of outputs carries the plain active and recovery counts. The other pair carries the same counts plus a fixed extra of 8 for the slow modes. Logic outside the block writes the values to the controller registers.

Top module: `pio_timing_calc`

## Requirements
- R1: The active count equals ceil(active_ns × f / 1000), where f is the effective clock in MHz. It appears on `act_a_o`, and on `act_b_o` after any offset from R3.
- R2: The recovery count equals ceil(cycle_ns × f / 1000) minus the active count. It appears on `rec_a_o`, and on `rec_b_o` after any offset from R3.
- R3: For modes 0, 1 and 2, `act_b_o` and `rec_b_o` are each 8 greater than `act_a_o` and `rec_a_o`. For modes 3 and 4 the two pairs are equal.
- R4: A `bus_mhz_i` value of 0 is treated as a 50 MHz clock.
- R5: Any `mode_i` value of 5, 6 or 7 gives the same results as mode 4.
- R6: The drive number is channel × 2 + unit. The four indexes (act_a, rec_a, act_b, rec_b), in hex, are 03/26/04/27 for drive 0, 05/28/06/29 for drive 1, 2B/30/2C/31 for drive 2 and 2D/32/2E/33 for drive 3.
- R7: The cycle and active times in ns are 600/165 for mode 0, 383/125 for mode 1, 240/100 for mode 2, 180/80 for mode 3 and 120/70 for mode 4.
- R8: `done_o` is high for exactly one cycle, 19 clock edges after the edge that captures `start_i` (for the default 8-bit clock input). All counts and indexes change only on the edge that raises `done_o`.
- R9: A `start_i` pulse that arrives while a calculation is running is ignored. It does not change the result, the latency or the number of done pulses.
- R10: While `rst_n` is low, `done_o`, all counts and all indexes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Capture inputs and begin a calculation |
| mode_i | input | 3 | Requested PIO mode; values above 4 are clamped |
| bus_mhz_i | input | CLK_W | Bus clock in MHz; 0 selects 50 |
| channel_i | input | 1 | Channel bit of the drive number |
| unit_i | input | 1 | Unit bit of the drive number |
| done_o | output | 1 | One-cycle result-valid strobe |
| act_a_o | output | CNT_W | Active count, first pair |
| rec_a_o | output | CNT_W | Recovery count, first pair |
| act_b_o | output | CNT_W | Active count, second pair (slow offset) |
| rec_b_o | output | CNT_W | Recovery count, second pair (slow offset) |
| idx_act_a_o | output | IDX_W | Register index for act_a_o |
| idx_rec_a_o | output | IDX_W | Register index for rec_a_o |
| idx_act_b_o | output | IDX_W | Register index for act_b_o |
| idx_rec_b_o | output | IDX_W | Register index for rec_b_o |

## Verification
The hardest case to reach is a second start pulse that lands while the dividers are running. From the ports it looks like a normal start, and it would be accepted if it arrived one cycle later. The stimulus starts a run and, a few cycles into it, pulses start again with a different mode, clock and drive. The bench then checks that the result, the latency and the index set all belong to the first request, and that no second done pulse follows. The rounding edge cases are reached by clock values that make the product an exact multiple of 1000, and by a 1 MHz clock whose full-cycle and active counts both round up to one.

// File: rtl/pio_calc_pkg.sv
package pio_calc_pkg;

   localparam int TIME_W     = 10;   // bits for a time in ns (max 600)
   localparam int MODE_W     = 3;
   localparam int MAX_MODE   = 4;
   localparam int SLOW_BELOW = 3;    // modes below this get the extra
   localparam int SLOW_EXTRA = 8;
   localparam int DEF_MHZ    = 50;
   localparam int NS_PER_US  = 1000;

   typedef struct packed {
      logic [TIME_W-1:0] cycle_ns;
      logic [TIME_W-1:0] active_ns;
   } mode_time_t;

   // Nominal times per transfer mode; anything above MAX_MODE maps to the fastest.
   function automatic mode_time_t lookup_mode(input logic [MODE_W-1:0] m);
      mode_time_t t;
      case (m)
         3'd0:    begin t.cycle_ns = 10'd600; t.active_ns = 10'd165; end
         3'd1:    begin t.cycle_ns = 10'd383; t.active_ns = 10'd125; end
         3'd2:    begin t.cycle_ns = 10'd240; t.active_ns = 10'd100; end
         3'd3:    begin t.cycle_ns = 10'd180; t.active_ns = 10'd80;  end
         default: begin t.cycle_ns = 10'd120; t.active_ns = 10'd70;  end
      endcase
      return t;
   endfunction

endpackage

// File: rtl/pio_ceil_div.sv
// Restoring divider by a constant; one quotient bit per clock.
module pio_ceil_div #(
   parameter int NUM_W = 18,
   parameter int DEN   = 1000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [NUM_W-1:0] num_i,
   output logic             busy_o,
   output logic [NUM_W-1:0] quo_o
);

   localparam int DEN_W = $clog2(DEN + 1);
   localparam int CTR_W = $clog2(NUM_W + 1);
   localparam logic [DEN_W:0] DEN_V = (DEN_W + 1)'(DEN);

   generate
      if (DEN < 2)     $error("divisor must be at least 2");
      if (NUM_W < DEN_W) $error("dividend narrower than divisor");
   endgenerate

   logic [DEN_W-1:0] rem_q;
   logic [NUM_W-1:0] quo_q;
   logic [CTR_W-1:0] ctr_q;

   logic [DEN_W:0]   trial;
   logic [DEN_W:0]   diff;
   logic             fits;

   always_comb begin
      trial = {rem_q, quo_q[NUM_W-1]};
      diff  = trial - DEN_V;
      fits  = (trial >= DEN_V);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q <= '0;
         quo_q <= '0;
         ctr_q <= '0;
      end else if (load_i) begin
         rem_q <= '0;
         quo_q <= num_i;
         ctr_q <= CTR_W'(NUM_W);
      end else if (ctr_q != '0) begin
         rem_q <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
         quo_q <= {quo_q[NUM_W-2:0], fits};
         ctr_q <= ctr_q - 1'b1;
      end
   end

   assign busy_o = (ctr_q != '0);
   assign quo_o  = quo_q;

   // partial remainder never reaches the divisor (R1, R2 rounding)
   p_rem_below_den_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rem_q < DEN_W'(DEN));

endmodule

// File: rtl/pio_reg_map.sv
// Maps a drive number to the register indexes of its four timing counts.
module pio_reg_map #(
   parameter int IDX_W = 8
) (
   input  logic [1:0]       drive_i,
   output logic [IDX_W-1:0] idx_act_a_o,
   output logic [IDX_W-1:0] idx_rec_a_o,
   output logic [IDX_W-1:0] idx_act_b_o,
   output logic [IDX_W-1:0] idx_rec_b_o
);

   generate
      if (IDX_W < 6) $error("index width too small for the index set");
   endgenerate

   always_comb begin
      case (drive_i)
         2'd0: begin
            idx_act_a_o = IDX_W'(8'h03); idx_rec_a_o = IDX_W'(8'h26);
            idx_act_b_o = IDX_W'(8'h04); idx_rec_b_o = IDX_W'(8'h27);
         end
         2'd1: begin
            idx_act_a_o = IDX_W'(8'h05); idx_rec_a_o = IDX_W'(8'h28);
            idx_act_b_o = IDX_W'(8'h06); idx_rec_b_o = IDX_W'(8'h29);
         end
         2'd2: begin
            idx_act_a_o = IDX_W'(8'h2B); idx_rec_a_o = IDX_W'(8'h30);
            idx_act_b_o = IDX_W'(8'h2C); idx_rec_b_o = IDX_W'(8'h31);
         end
         default: begin
            idx_act_a_o = IDX_W'(8'h2D); idx_rec_a_o = IDX_W'(8'h32);
            idx_act_b_o = IDX_W'(8'h2E); idx_rec_b_o = IDX_W'(8'h33);
         end
      endcase
   end

endmodule

// File: rtl/pio_timing_calc.sv
module pio_timing_calc
   import pio_calc_pkg::*;
#(
   parameter int CLK_W = 8,
   parameter int CNT_W = 8,
   parameter int IDX_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [MODE_W-1:0] mode_i,
   input  logic [CLK_W-1:0]  bus_mhz_i,
   input  logic              channel_i,
   input  logic              unit_i,
   output logic              done_o,
   output logic [CNT_W-1:0]  act_a_o,
   output logic [CNT_W-1:0]  rec_a_o,
   output logic [CNT_W-1:0]  act_b_o,
   output logic [CNT_W-1:0]  rec_b_o,
   output logic [IDX_W-1:0]  idx_act_a_o,
   output logic [IDX_W-1:0]  idx_rec_a_o,
   output logic [IDX_W-1:0]  idx_act_b_o,
   output logic [IDX_W-1:0]  idx_rec_b_o
);

   localparam int NUM_W  = TIME_W + CLK_W;
   localparam int N_DIV  = 2;          // 0: active time, 1: full cycle
   localparam int SEL_ACT = 0;
   localparam int SEL_CYC = 1;

   generate
      if (CLK_W < 6)      $error("clock input cannot hold the default clock");
      if (CNT_W < 5)      $error("count width cannot hold the slow offset");
      if (NUM_W < CNT_W)  $error("quotient narrower than the counts");
   endgenerate

   // ---------------- input conditioning ----------------
   logic [MODE_W-1:0] mode_eff;
   mode_time_t        tm;
   logic [CLK_W-1:0]  f_eff;
   logic [NUM_W-1:0]  num_v  [N_DIV];
   logic [NUM_W-1:0]  quo_v  [N_DIV];
   logic [N_DIV-1:0]  div_busy;

   always_comb begin
      mode_eff = (mode_i > MODE_W'(MAX_MODE)) ? MODE_W'(MAX_MODE) : mode_i;
      tm       = lookup_mode(mode_eff);
      f_eff    = (bus_mhz_i == '0) ? CLK_W'(DEF_MHZ) : bus_mhz_i;
      num_v[SEL_ACT] = NUM_W'(tm.active_ns) * NUM_W'(f_eff) + NUM_W'(NS_PER_US - 1);
      num_v[SEL_CYC] = NUM_W'(tm.cycle_ns)  * NUM_W'(f_eff) + NUM_W'(NS_PER_US - 1);
   end

   // ---------------- control ----------------
   logic       busy_q;
   logic       slow_q;
   logic [1:0] drive_q;
   logic       load;
   logic       finish;

   assign load   = start_i & ~busy_q;
   assign finish = busy_q & ~div_busy[SEL_ACT];

   // ---------------- dividers ----------------
   generate
      for (genvar g = 0; g < N_DIV; g++) begin : g_div
         pio_ceil_div #(
            .NUM_W (NUM_W),
            .DEN   (NS_PER_US)
         ) u_div (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (load),
            .num_i  (num_v[g]),
            .busy_o (div_busy[g]),
            .quo_o  (quo_v[g])
         );
      end
   endgenerate

   // ---------------- result shaping ----------------
   logic [CNT_W-1:0] act_c;
   logic [CNT_W-1:0] rec_c;
   logic [CNT_W-1:0] add_c;
   logic [IDX_W-1:0] map_act_a;
   logic [IDX_W-1:0] map_rec_a;
   logic [IDX_W-1:0] map_act_b;
   logic [IDX_W-1:0] map_rec_b;

   always_comb begin
      act_c = quo_v[SEL_ACT][CNT_W-1:0];
      rec_c = quo_v[SEL_CYC][CNT_W-1:0] - act_c;
      add_c = slow_q ? CNT_W'(SLOW_EXTRA) : '0;
   end

   pio_reg_map #(.IDX_W(IDX_W)) u_map (
      .drive_i     (drive_q),
      .idx_act_a_o (map_act_a),
      .idx_rec_a_o (map_rec_a),
      .idx_act_b_o (map_act_b),
      .idx_rec_b_o (map_rec_b)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q      <= 1'b0;
         slow_q      <= 1'b0;
         drive_q     <= '0;
         done_o      <= 1'b0;
         act_a_o     <= '0;
         rec_a_o     <= '0;
         act_b_o     <= '0;
         rec_b_o     <= '0;
         idx_act_a_o <= '0;
         idx_rec_a_o <= '0;
         idx_act_b_o <= '0;
         idx_rec_b_o <= '0;
      end else begin
         done_o <= finish;
         if (load) begin
            busy_q  <= 1'b1;
            slow_q  <= (mode_eff < MODE_W'(SLOW_BELOW));
            drive_q <= {channel_i, unit_i};
         end else if (finish) begin
            busy_q      <= 1'b0;
            act_a_o     <= act_c;
            rec_a_o     <= rec_c;
            act_b_o     <= act_c + add_c;
            rec_b_o     <= rec_c + add_c;
            idx_act_a_o <= map_act_a;
            idx_rec_a_o <= map_rec_a;
            idx_act_b_o <= map_act_b;
            idx_rec_b_o <= map_rec_b;
         end
      end
   end

   // ---------------- assertions ----------------
   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_hold_counts_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(act_a_o) && $stable(rec_a_o) &&
                   $stable(act_b_o) && $stable(rec_b_o) && $stable(idx_act_a_o)));

   p_pair_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (((act_b_o - act_a_o) == CNT_W'(0)) ||
                  ((act_b_o - act_a_o) == CNT_W'(SLOW_EXTRA))) &&
                 ((rec_b_o - rec_a_o) == (act_b_o - act_a_o)));

   p_idx_pairs_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (idx_act_b_o == idx_act_a_o + 1'b1) &&
                 (idx_rec_b_o == idx_rec_a_o + 1'b1));

   p_busy_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && div_busy[SEL_ACT] && start_i) |=> busy_q && $stable(drive_q));

endmodule

// File: tb/pio_timing_calc_tb_top.sv
`timescale 1ns/1ps
module pio_timing_calc_tb_top;

   localparam int EXP_LAT = 20;   // posedges counted from capture, see run task
   localparam int NV = 9;
   localparam int NC = 12;
   // mode, mhz, channel, unit, act_a, rec_a, act_b, rec_b, idx x4
   localparam int VEC [NV][NC] = '{
      '{0,   0, 0, 0,  9,  21, 17,  29, 'h03, 'h26, 'h04, 'h27},
      '{4,  33, 0, 1,  3,   1,  3,   1, 'h05, 'h28, 'h06, 'h29},
      '{2,  66, 1, 0,  7,   9, 15,  17, 'h2B, 'h30, 'h2C, 'h31},
      '{3, 100, 1, 1,  8,  10,  8,  10, 'h2D, 'h32, 'h2E, 'h33},
      '{7, 255, 0, 0, 18,  13, 18,  13, 'h03, 'h26, 'h04, 'h27},
      '{1, 255, 1, 1, 32,  66, 40,  74, 'h2D, 'h32, 'h2E, 'h33},
      '{0, 255, 0, 1, 43, 110, 51, 118, 'h05, 'h28, 'h06, 'h29},
      '{2,   1, 1, 0,  1,   0,  9,   8, 'h2B, 'h30, 'h2C, 'h31},
      '{3,  50, 0, 0,  4,   5,  4,   5, 'h03, 'h26, 'h04, 'h27}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [2:0] mode_i = '0;
   logic [7:0] bus_mhz_i = '0;
   logic       channel_i = 1'b0;
   logic       unit_i = 1'b0;
   logic       done_o;
   logic [7:0] act_a_o, rec_a_o, act_b_o, rec_b_o;
   logic [7:0] idx_act_a_o, idx_rec_a_o, idx_act_b_o, idx_rec_b_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   pio_timing_calc dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
      .bus_mhz_i(bus_mhz_i), .channel_i(channel_i), .unit_i(unit_i),
      .done_o(done_o), .act_a_o(act_a_o), .rec_a_o(rec_a_o),
      .act_b_o(act_b_o), .rec_b_o(rec_b_o),
      .idx_act_a_o(idx_act_a_o), .idx_rec_a_o(idx_rec_a_o),
      .idx_act_b_o(idx_act_b_o), .idx_rec_b_o(idx_rec_b_o)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic check_all(input string req, input int v);
      check({req, " act_a"}, int'(act_a_o), VEC[v][4]);
      check({req, " rec_a"}, int'(rec_a_o), VEC[v][5]);
      check({req, " act_b"}, int'(act_b_o), VEC[v][6]);
      check({req, " rec_b"}, int'(rec_b_o), VEC[v][7]);
      check({req, " R6 idx_act_a"}, int'(idx_act_a_o), VEC[v][8]);
      check({req, " R6 idx_rec_a"}, int'(idx_rec_a_o), VEC[v][9]);
      check({req, " R6 idx_act_b"}, int'(idx_act_b_o), VEC[v][10]);
      check({req, " R6 idx_rec_b"}, int'(idx_rec_b_o), VEC[v][11]);
   endtask

   // Starts a run at a negedge; returns posedges until done is seen.
   // mid_at > 0 pulses start again (vector mid_v) that many cycles in.
   task automatic run(input int v, input int mid_at, input int mid_v, output int lat);
      mode_i    = 3'(VEC[v][0]);
      bus_mhz_i = 8'(VEC[v][1]);
      channel_i = VEC[v][2][0];
      unit_i    = VEC[v][3][0];
      start_i   = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      lat = 1;
      while (!done_o && lat < 100) begin
         if (lat == mid_at) begin
            mode_i    = 3'(VEC[mid_v][0]);
            bus_mhz_i = 8'(VEC[mid_v][1]);
            channel_i = VEC[mid_v][2][0];
            unit_i    = VEC[mid_v][3][0];
            start_i   = 1'b1;
         end
         @(posedge clk);
         lat++;
         @(negedge clk);
         start_i = 1'b0;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int lat;
      int ndone;
      logic [7:0] ref_a [4];
      // R10: reset state
      repeat (3) @(negedge clk);
      check("R10 done", int'(done_o), 0);
      check("R10 act_a", int'(act_a_o), 0);
      check("R10 rec_b", int'(rec_b_o), 0);
      check("R10 idx_act_a", int'(idx_act_a_o), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // vector walk: R1 R2 R3 R4 R5 R7 R6 R8
      for (int v = 0; v < NV; v++) begin
         run(v, 0, 0, lat);
         check("R8 latency", lat, EXP_LAT);
         check_all("R1 R2 R3 R7", v);
         @(negedge clk);
         check("R8 done single", int'(done_o), 0);
         check("R8 hold act_b", int'(act_b_o), VEC[v][6]);
         repeat (3) @(negedge clk);
      end

      // R5: modes 5 and 6 match mode 4 at the same clock
      run(1, 0, 0, lat);
      ref_a[0] = act_a_o; ref_a[1] = rec_a_o; ref_a[2] = act_b_o; ref_a[3] = rec_b_o;
      for (int m = 5; m < 7; m++) begin
         mode_i = 3'(m); bus_mhz_i = 8'd33; channel_i = 1'b0; unit_i = 1'b1;
         start_i = 1'b1;
         @(posedge clk);
         @(negedge clk);
         start_i = 1'b0;
         while (!done_o) @(negedge clk);
         check("R5 clamp act_a", int'(act_a_o), int'(ref_a[0]));
         check("R5 clamp rec_a", int'(rec_a_o), int'(ref_a[1]));
         check("R5 clamp act_b", int'(act_b_o), int'(ref_a[2]));
         check("R5 clamp rec_b", int'(rec_b_o), int'(ref_a[3]));
         @(negedge clk);
      end

      // R9: start during a run with other inputs is ignored
      run(5, 5, 7, lat);
      check("R9 latency", lat, EXP_LAT);
      check_all("R9 first request kept", 5);
      ndone = 0;
      for (int c = 0; c < 30; c++) begin
         @(negedge clk);
         if (done_o) ndone++;
      end
      check("R9 no extra done", ndone, 0);
      check("R9 outputs held", int'(act_a_o), VEC[5][4]);

      // R10: reset again clears outputs
      rst_n = 1'b0;
      @(negedge clk);
      check("R10 act_a after reset", int'(act_a_o), 0);
      check("R10 idx_rec_b after reset", int'(idx_rec_b_o), 0);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule